// File: doc/BRIEF.md
# Two-Way Write-Back Cache Controller

This block sits between a processor that issues single-word loads and stores and a slower main memory that moves whole lines through a request/acknowledge handshake. Each word address is cut into a line offset, a set index and a tag. Both ways of the indexed set are compared at once. A hit is served in the cycle of the request. A miss stalls the processor. If the chosen victim holds modified data, it is first copied back to memory. The missing line is then fetched, and the held request is replayed as a hit.

Stores update only the cache and mark their line modified. Memory sees a store only when that line is evicted. Victim selection takes an empty way first. Otherwise it takes the way of the set that was used least recently, tracked by one bit per set. The processor must hold its request, address, write flag and write data steady for as long as ready stays low.

Top module: `sa_wb_cache`

## Requirements
- R1: After reset no line is valid. With no request pending, `cpu_ready` is 1 and `mem_req` is 0, and the first access to any address is a miss.
- R2: For the default 10-bit word address, bits [1:0] select the word in a line, bits [5:2] select one of 16 sets and bits [9:6] form the tag. `mem_addr` carries the line address {tag, set}. On a refill that is the requested line; on a write-back it is the victim's stored tag with the same set.
- R3: A request that hits raises `cpu_ready` in the request cycle. On a load, `cpu_rdata` in that cycle is the stored word.
- R4: Lines with different tags that share a set are resident in the two ways together, and both hit.
- R5: A miss fetches the whole 4-word line in one memory transaction. Word k of the line travels in bits [32k+31:32k] of `mem_rline` and `mem_wline`. Later loads to the other words of that line hit with memory's values.
- R6: A store that hits writes only the addressed word, marks the line modified and starts no memory transaction.
- R7: When the victim is modified, one memory write (`mem_we`=1) of the victim line precedes the refill read. Memory then holds the stored data.
- R8: A victim that was never stored to since its fill is dropped without a memory write.
- R9: When both ways of the set are valid, the victim is the way not touched most recently. Both hits and fills count as touches.
- R10: When a way of the set is invalid, that way is filled and no valid line is evicted.
- R11: A store that misses is completed once the refill ends. The refilled line is then modified and is written back with the stored word when it is later evicted.
- R12: During a miss `cpu_ready` stays 0. `mem_req` stays 1 until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 10 | Word address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid while `cpu_ready` with a load |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_req | output | 1 | Line transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line refill |
| mem_addr | output | 8 | Line address {tag, set} |
| mem_wline | output | 128 | Victim line for a write-back |
| mem_rline | input | 128 | Refill line, sampled with `mem_ack` |
| mem_ack | input | 1 | Memory completes the transaction |

## Verification
The hardest case to reach is the eviction of a modified line that the replacement bit, not an empty way, has chosen. Both ways of one set must be filled, one of them stored to, and the other touched more recently. The stimulus drives a fixed sequence through a single set that builds exactly that history. It then refetches the evicted address to show that the stored word went to memory, and repeats the pattern with a store that misses so the replayed store's line is evicted later.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } cstate_e;
endpackage

// File: rtl/cache_tags.sv
module cache_tags
  import cache_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             touch,
  input  logic             mark_dirty,
  input  logic             fill,
  output logic             hit,
  output logic             hit_way,
  output logic             vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [WAYS-1:0]             match;
  logic [WAYS-1:0]             vld;
  logic [WAYS-1:0]             dty;
  logic [WAYS-1:0][TAG_W-1:0]  tagv;
  logic [SETS-1:0]             lru_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dirty_q;

    assign vld[w]   = vld_q[idx];
    assign dty[w]   = dirty_q[idx];
    assign tagv[w]  = tag_q[idx];
    assign match[w] = vld_q[idx] && (tag_q[idx] == tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q   <= '0;
        dirty_q <= '0;
      end else if (fill && (vic_way == 1'(w))) begin
        vld_q[idx]   <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (mark_dirty && (hit_way == 1'(w))) begin
        dirty_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill && (vic_way == 1'(w))) tag_q[idx] <= tag;
    end
  end

  always_comb begin
    hit     = |match;
    hit_way = match[1];
    if (!vld[0])      vic_way = 1'b0;
    else if (!vld[1]) vic_way = 1'b1;
    else              vic_way = lru_q[idx];
    vic_dirty = vld[vic_way] && dty[vic_way];
    vic_tag   = tagv[vic_way];
  end

  // lru_q holds the way to evict next in each set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lru_q      <= '0;
    else if (fill)  lru_q[idx] <= ~vic_way;
    else if (touch) lru_q[idx] <= ~hit_way;
  end
endmodule

// File: rtl/cache_data.sv
module cache_data
  import cache_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int IDX_W      = 4
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             idx,
  input  logic [$clog2(LINE_WORDS)-1:0] off,
  input  logic                         rd_way,
  input  logic                         vic_way,
  input  logic                         wr_en,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         fill,
  input  logic [DATA_W*LINE_WORDS-1:0] fill_line,
  output logic [DATA_W-1:0]            rd_word,
  output logic [DATA_W*LINE_WORDS-1:0] vic_line
);
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;

  logic [WAYS-1:0][LINE_W-1:0] lines;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];
    assign lines[w] = line_q[idx];

    always_ff @(posedge clk) begin
      if (fill && (vic_way == 1'(w)))
        line_q[idx] <= fill_line;
      else if (wr_en && (rd_way == 1'(w)))
        line_q[idx][off*DATA_W +: DATA_W] <= wdata;
    end
  end

  assign rd_word  = lines[rd_way][off*DATA_W +: DATA_W];
  assign vic_line = lines[vic_way];
endmodule

// File: rtl/cache_fsm.sv
module cache_fsm
  import cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic we,
  input  logic hit,
  input  logic vic_dirty,
  input  logic mem_ack,
  output logic ready,
  output logic word_we,
  output logic touch,
  output logic fill,
  output logic mem_req,
  output logic mem_we
);
  cstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ready   = 1'b0;
    touch   = 1'b0;
    word_we = 1'b0;
    fill    = 1'b0;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        ready   = !req || hit;
        touch   = req && hit;
        word_we = req && hit && we;
        if (req && !hit) state_d = vic_dirty ? ST_WBACK : ST_FILL;
      end
      ST_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          fill    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         cpu_req,
  input  logic                                         cpu_we,
  input  logic [ADDR_W-1:0]                            cpu_addr,
  input  logic [DATA_W-1:0]                            cpu_wdata,
  output logic [DATA_W-1:0]                            cpu_rdata,
  output logic                                         cpu_ready,
  output logic                                         mem_req,
  output logic                                         mem_we,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]         mem_addr,
  output logic [DATA_W*LINE_WORDS-1:0]                 mem_wline,
  input  logic [DATA_W*LINE_WORDS-1:0]                 mem_rline,
  input  logic                                         mem_ack
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W  = ADDR_W - OFF_W;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  assign {a_tag, a_idx, a_off} = cpu_addr;

  logic             hit, hit_way, vic_way, vic_dirty;
  logic [TAG_W-1:0] vic_tag;
  logic             word_we, touch, fill;

  cache_tags #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_core_n), .idx(a_idx), .tag(a_tag),
    .touch(touch), .mark_dirty(word_we), .fill(fill),
    .hit(hit), .hit_way(hit_way), .vic_way(vic_way),
    .vic_dirty(vic_dirty), .vic_tag(vic_tag)
  );

  cache_data #(.DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W)) u_data (
    .clk(clk), .idx(a_idx), .off(a_off), .rd_way(hit_way), .vic_way(vic_way),
    .wr_en(word_we), .wdata(cpu_wdata), .fill(fill), .fill_line(mem_rline),
    .rd_word(cpu_rdata), .vic_line(mem_wline)
  );

  cache_fsm u_fsm (
    .clk(clk), .rst_n(rst_core_n), .req(cpu_req), .we(cpu_we), .hit(hit),
    .vic_dirty(vic_dirty), .mem_ack(mem_ack), .ready(cpu_ready),
    .word_we(word_we), .touch(touch), .fill(fill),
    .mem_req(mem_req), .mem_we(mem_we)
  );

  assign mem_addr = mem_we ? LA_W'({vic_tag, a_idx}) : LA_W'({a_tag, a_idx});
endmodule

// File: rtl/sa_wb_cache_chk.sv
module sa_wb_cache_chk #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 2,
  parameter int LA_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [LA_W-1:0]   mem_addr,
  input logic              mem_ack
);
  a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  a_r12_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  a_r7_fill_follows_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

  a_r2_refill_line: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == LA_W'(cpu_addr >> OFF_W)));

  a_r11_replay_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> cpu_ready);
endmodule

bind sa_wb_cache sa_wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LA_W(LA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sa_wb_cache_bench.sv
module sa_wb_cache_bench;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int LW  = 128;
  localparam int LAT = 3;
  localparam int VW  = 86;
  localparam int NV  = 15;

  // {we, addr, wdata, exp_rdata, exp_hit, exp_wb, exp_fill, exp_wb_line}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 10'h04D, 32'h0,        32'hC0DE004D, 1'b0, 1'b0, 1'b1, 8'h00}, // R1 R10 first miss
    {1'b0, 10'h04F, 32'h0,        32'hC0DE004F, 1'b1, 1'b0, 1'b0, 8'h00}, // R5 rest of line hits
    {1'b0, 10'h08C, 32'h0,        32'hC0DE008C, 1'b0, 1'b0, 1'b1, 8'h00}, // R10 empty way used
    {1'b0, 10'h04C, 32'h0,        32'hC0DE004C, 1'b1, 1'b0, 1'b0, 8'h00}, // R4 both ways live
    {1'b1, 10'h08E, 32'h11112222, 32'h0,        1'b1, 1'b0, 1'b0, 8'h00}, // R6 store hit
    {1'b0, 10'h08E, 32'h0,        32'h11112222, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 word updated
    {1'b0, 10'h0CC, 32'h0,        32'hC0DE00CC, 1'b0, 1'b0, 1'b1, 8'h00}, // R9 R8 clean LRU victim
    {1'b0, 10'h04C, 32'h0,        32'hC0DE004C, 1'b0, 1'b1, 1'b1, 8'h23}, // R7 dirty victim
    {1'b0, 10'h08E, 32'h0,        32'h11112222, 1'b0, 1'b0, 1'b1, 8'h00}, // R7 memory got store
    {1'b1, 10'h10D, 32'h33334444, 32'h0,        1'b0, 1'b0, 1'b1, 8'h00}, // R11 store miss
    {1'b0, 10'h10D, 32'h0,        32'h33334444, 1'b1, 1'b0, 1'b0, 8'h00}, // R11 store applied
    {1'b0, 10'h0CD, 32'h0,        32'hC0DE00CD, 1'b0, 1'b0, 1'b1, 8'h00}, // R8 refetched line clean
    {1'b0, 10'h04C, 32'h0,        32'hC0DE004C, 1'b0, 1'b1, 1'b1, 8'h43}, // R11 dirty after replay
    {1'b0, 10'h10D, 32'h0,        32'h33334444, 1'b0, 1'b0, 1'b1, 8'h00}, // R11 data reached memory
    {1'b0, 10'h3F0, 32'h0,        32'hC0DE03F0, 1'b0, 1'b0, 1'b1, 8'h00}  // R2 other set
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           cpu_req, cpu_we;
  logic [AW-1:0]  cpu_addr;
  logic [DW-1:0]  cpu_wdata, cpu_rdata;
  logic           cpu_ready;
  logic           mem_req, mem_we, mem_ack;
  logic [7:0]     mem_addr;
  logic [LW-1:0]  mem_wline, mem_rline;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] mem_q [1024];
  int            mem_cnt = 0;
  int            wb_cnt = 0;
  int            fill_cnt = 0;
  logic [7:0]    last_wb, last_fill;

  always #2 clk = ~clk;

  sa_wb_cache u_sa_wb_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wline(mem_wline), .mem_rline(mem_rline),
    .mem_ack(mem_ack)
  );

  // memory model: acknowledges after LAT stall cycles, one-cycle ack pulse
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_cnt = 0;
    end else if (mem_req) begin
      if (mem_cnt == LAT) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++) mem_q[{mem_addr, 2'(k)}] = mem_wline[k*32 +: 32];
          wb_cnt++;
          last_wb = mem_addr;
        end else begin
          for (int k = 0; k < 4; k++) mem_rline[k*32 +: 32] = mem_q[{mem_addr, 2'(k)}];
          fill_cnt++;
          last_fill = mem_addr;
        end
        mem_ack = 1'b1;
      end else begin
        mem_cnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        output logic hit, output logic [DW-1:0] rd,
                        output int wbs, output int fills, output int stall);
    int w0, f0;
    bit fin;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    w0 = wb_cnt; f0 = fill_cnt; stall = 0; fin = 0; hit = 1'b0; rd = '0;
    while (!fin && stall < 100) begin
      #1;
      if (cpu_ready) begin
        hit = (stall == 0);
        rd  = cpu_rdata;
        fin = 1;
      end else begin
        stall++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    wbs = wb_cnt - w0;
    fills = fill_cnt - f0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cpu_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic hit;
    logic [DW-1:0] rd;
    int wbs, fills, stall;
    for (int i = 0; i < 1024; i++) mem_q[i] = 32'hC0DE0000 | 32'(i);
    mem_ack = 1'b0; mem_rline = '0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    do_reset();

    // R1: idle outputs after reset
    #1;
    chk("R1 idle ready", 32'(cpu_ready), 32'd1);
    chk("R1 no mem request", 32'(mem_req), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      access(v[85], v[84:75], v[74:43], hit, rd, wbs, fills, stall);
      chk($sformatf("R3 hit flag step %0d", i), 32'(hit), 32'(v[10]));
      if (!v[85]) chk($sformatf("R5 rdata step %0d", i), rd, v[42:11]);
      chk($sformatf("R7 R8 writebacks step %0d", i), 32'(wbs), 32'(v[9]));
      chk($sformatf("R5 fills step %0d", i), 32'(fills), 32'(v[8]));
      if (v[9]) chk($sformatf("R2 victim line step %0d", i), 32'(last_wb), 32'(v[7:0]));
      if (v[8]) begin
        chk($sformatf("R2 refill line step %0d", i), 32'(last_fill), 32'(v[84:77]));
        chk($sformatf("R12 stall length step %0d", i), 32'(stall >= LAT + 1), 32'd1);
      end
    end

    // R1: reset in mid-run clears validity; resident line misses again
    access(1'b0, 10'h3F1, '0, hit, rd, wbs, fills, stall);
    chk("R3 resident before reset", 32'(hit), 32'd1);
    do_reset();
    #1;
    chk("R1 ready after second reset", 32'(cpu_ready), 32'd1);
    access(1'b0, 10'h3F1, '0, hit, rd, wbs, fills, stall);
    chk("R1 miss after reset", 32'(hit), 32'd0);
    chk("R1 refill data", rd, 32'hC0DE03F1);
    chk("R8 no writeback after reset", 32'(wbs), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule